// File: doc/BRIEF.md
# Bank-Rank Rotating Burst Sequencer

This block produces deterministic DRAM test traffic. It issues a series of back-to-back burst requests to consecutive columns of one open page. It then moves on to a new series in a fixed order. The bank advances first. When the traffic mixes reads and writes, the command type changes after every bank has been visited once. The rank changes after that. The order comes from a single wrapping rotation position that advances once for each series. Each series start also draws a pseudo-random row, and a start column low enough that the whole series stays inside one page.

A memory-test harness sets the configuration, raises `run_en` and takes requests over a valid/ready handshake. Each request carries a full byte address and a write flag. An unsupported configuration raises `cfg_err` and no traffic leaves the block. The configuration is meant to stay fixed while `run_en` is high or a series is still in flight. Request spacing and the memory model are outside the block.

Top module: `rot_seq_gen`

## Requirements
- R1: `cfg_err` is high and `req_valid` is low whenever the configuration is unsupported. The unsupported cases are: `cfg_rd_pct` other than 0, 50 or 100; `cfg_banks_used` equal to 0 or above 2^BANK_BITS; `cfg_ranks` equal to 0 or above 2^RANK_BITS; `cfg_series_len` equal to 0 or above the columns per page (2^COL_BITS).
- R2: A series is exactly `cfg_series_len` accepted requests. Within a series the row, bank, rank and direction are fixed, and the column rises by one with each accepted request. While `req_valid` is high and `req_ready` is low, `req_addr` and `req_write` hold.
- R3: Number the series 0, 1, 2, … from reset. Series k targets bank k mod `cfg_banks_used`.
- R4: Series k targets rank floor(k / S) mod `cfg_ranks`. S is 2×`cfg_banks_used` when `cfg_rd_pct` is 50, and `cfg_banks_used` otherwise.
- R5: With `cfg_rd_pct` = 50, series k reads (`req_write`=0) when floor(k / `cfg_banks_used`) is even and writes otherwise. The direction flips at every series start whose bank is 0.
- R6: With `cfg_rd_pct` = 100 every request reads (`req_write`=0). With 0 every request writes (`req_write`=1).
- R7: The start column of a series is at most 2^COL_BITS − `cfg_series_len`, so every burst of the series falls in the same page.
- R8: Address layout. Bits [BLK_BITS-1:0] are zero and the row occupies the top bits. With `cfg_map`=1 the column sits at bit BLK_BITS, then the bank, then the rank above it. With `cfg_map`=0 the bank sits at bit BLK_BITS, then the rank, then the column above it.
- R9: With `run_en` and `req_ready` held high, the last request of one series is followed in the very next cycle by the first request of the next series.
- R10: While `run_en` is low no new series starts, but a series already in progress completes. After `run_en` returns, the rotation resumes with the next series number.
- R11: After reset `req_valid` is low, the rotation position is 0 and the direction state is write, so the first series of a 50% mix reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Allows new series to start |
| cfg_rd_pct | input | 7 | Read percentage: 0, 50 or 100 |
| cfg_banks_used | input | BANK_BITS+1 | Banks visited per rank (1..2^BANK_BITS) |
| cfg_ranks | input | RANK_BITS+1 | Ranks visited (1..2^RANK_BITS) |
| cfg_series_len | input | COL_BITS+1 | Requests per series (1..2^COL_BITS) |
| cfg_map | input | 1 | Address layout select, see R8 |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high together with req_valid |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_write | output | 1 | 1 = write, 0 = read |
| cfg_err | output | 1 | Unsupported configuration |

## Verification
Two things can fall in the same clock edge: the acceptance of the last burst of a series, and the choice of bank, rank, row and column for the next series. The bench provokes this by holding `req_ready` and `run_en` high across many series. Every table entry then runs as one unbroken stream of requests. Each cycle must carry a valid request whose decoded fields match the series number expected for its position, so a dropped or doubled series start shows up as a gap or as a shifted bank and rank.

// File: rtl/rot_seq_pkg.sv
package rot_seq_pkg;

   typedef enum logic {
      MAP_BANK_LOW = 1'b0,   // column field above bank and rank
      MAP_COL_LOW  = 1'b1    // column field directly above the burst offset
   } addr_map_e;

   localparam logic [6:0] PCT_WRITES = 7'd0;
   localparam logic [6:0] PCT_MIX    = 7'd50;
   localparam logic [6:0] PCT_READS  = 7'd100;

   // Right-shifting Galois feedback masks for the supported LFSR widths.
   function automatic logic [63:0] lfsr_taps(input int width);
      case (width)
         16:      return 64'h0000_0000_0000_B400;
         24:      return 64'h0000_0000_00E1_0000;
         32:      return 64'h0000_0000_8020_0003;
         default: return 64'h0;
      endcase
   endfunction

   function automatic logic pct_legal(input logic [6:0] pct);
      return (pct == PCT_WRITES) || (pct == PCT_MIX) || (pct == PCT_READS);
   endfunction

endpackage

// File: rtl/rot_seq_lfsr.sv
module rot_seq_lfsr #(
   parameter int             W    = 32,
   parameter logic [W-1:0]   SEED = W'(32'h1ACE_5EED)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] TAPS = W'(rot_seq_pkg::lfsr_taps(W));

   generate
      if (TAPS == '0) begin : g_bad_width
         $error("rot_seq_lfsr: width %0d has no feedback mask", W);
      end
      if (SEED == '0) begin : g_bad_seed
         $error("rot_seq_lfsr: seed must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SEED;
      end else if (step) begin
         state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
      end
   end

   // A zero state would freeze row and column selection (R7 relies on variety).
   p_lfsr_live_r7: assert property (@(posedge clk) disable iff (rst)
      state != '0);

endmodule

// File: rtl/rot_seq_rotation.sv
module rot_seq_rotation #(
   parameter int BANK_BITS = 3,
   parameter int RANK_BITS = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 advance,
   input  logic [BANK_BITS:0]   banks_used,
   input  logic [RANK_BITS:0]   ranks,
   input  logic                 mix,
   input  logic                 rd_all,
   output logic [BANK_BITS-1:0] bank_sel,
   output logic [RANK_BITS-1:0] rank_sel,
   output logic                 dir_rd
);
   logic [BANK_BITS-1:0] bank_q;
   logic [RANK_BITS-1:0] rank_q;
   logic                 phase_q;
   logic                 last_bank;
   logic                 last_rank;

   always_comb begin
      last_bank = ((BANK_BITS+1)'(bank_q) + (BANK_BITS+1)'(1)) >= banks_used;
      last_rank = ((RANK_BITS+1)'(rank_q) + (RANK_BITS+1)'(1)) >= ranks;
      bank_sel  = bank_q;
      rank_sel  = rank_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q  <= '0;
         rank_q  <= '0;
         phase_q <= 1'b0;
         dir_rd  <= 1'b0;
      end else if (advance) begin
         if (mix) begin
            if (bank_q == '0) dir_rd <= ~dir_rd;
         end else begin
            dir_rd <= rd_all;
         end
         if (last_bank) begin
            bank_q <= '0;
            if (mix && !phase_q) begin
               phase_q <= 1'b1;
            end else begin
               phase_q <= 1'b0;
               rank_q  <= last_rank ? '0 : rank_q + 1'b1;
            end
         end else begin
            bank_q <= bank_q + 1'b1;
         end
      end
   end

   p_mix_flip_r5: assert property (@(posedge clk) disable iff (rst)
      advance && mix && (bank_sel == '0) |=> dir_rd != $past(dir_rd));

   p_fixed_dir_r6: assert property (@(posedge clk) disable iff (rst)
      advance && !mix |=> dir_rd == $past(rd_all));

   p_rank_hold_r4: assert property (@(posedge clk) disable iff (rst)
      advance && !last_bank |=> $stable(rank_sel));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !advance |=> $stable(bank_sel) && $stable(rank_sel) && $stable(dir_rd));

endmodule

// File: rtl/rot_seq_addr_map.sv
module rot_seq_addr_map import rot_seq_pkg::*; #(
   parameter int BLK_BITS  = 6,
   parameter int COL_BITS  = 5,
   parameter int BANK_BITS = 3,
   parameter int RANK_BITS = 1,
   parameter int ROW_W     = 17,
   localparam int ADDR_W   = ROW_W + COL_BITS + BANK_BITS + RANK_BITS + BLK_BITS
) (
   input  addr_map_e            map_sel,
   input  logic [ROW_W-1:0]     row,
   input  logic [RANK_BITS-1:0] rank,
   input  logic [BANK_BITS-1:0] bank,
   input  logic [COL_BITS-1:0]  col,
   output logic [ADDR_W-1:0]    addr
);
   localparam logic [BLK_BITS-1:0] BLK_ZERO = '0;

   always_comb begin
      case (map_sel)
         MAP_COL_LOW:  addr = {row, rank, bank, col, BLK_ZERO};
         default:      addr = {row, col, rank, bank, BLK_ZERO};
      endcase
   end

endmodule

// File: rtl/rot_seq_gen.sv
module rot_seq_gen import rot_seq_pkg::*; #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BITS  = 6,
   parameter int COL_BITS  = 5,
   parameter int BANK_BITS = 3,
   parameter int RANK_BITS = 1,
   parameter int LFSR_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 run_en,
   input  logic [6:0]           cfg_rd_pct,
   input  logic [BANK_BITS:0]   cfg_banks_used,
   input  logic [RANK_BITS:0]   cfg_ranks,
   input  logic [COL_BITS:0]    cfg_series_len,
   input  logic                 cfg_map,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [ADDR_W-1:0]    req_addr,
   output logic                 req_write,
   output logic                 cfg_err
);
   localparam int COLS      = 1 << COL_BITS;
   localparam int NUM_BANKS = 1 << BANK_BITS;
   localparam int NUM_RANKS = 1 << RANK_BITS;
   localparam int ROW_W     = ADDR_W - BLK_BITS - COL_BITS - BANK_BITS - RANK_BITS;
   localparam int COL_RND_W = COL_BITS + 2;

   generate
      if (BLK_BITS < 1 || COL_BITS < 1 || BANK_BITS < 1 || RANK_BITS < 1) begin : g_bad_field
         $error("rot_seq_gen: every address field needs at least one bit");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("rot_seq_gen: ADDR_W leaves no row bits");
      end
      if (LFSR_W < ROW_W + COL_RND_W) begin : g_bad_lfsr
         $error("rot_seq_gen: LFSR_W too narrow for row and column draw");
      end
   endgenerate

   logic                 cfg_ok;
   logic                 mix_mode;
   logic                 rd_all;
   logic                 fire;
   logic                 start;
   logic [COL_BITS:0]    rem_q;
   logic [COL_BITS:0]    col_span;
   logic [COL_BITS:0]    span_safe;
   logic [COL_BITS-1:0]  col_q;
   logic [COL_BITS-1:0]  start_col;
   logic [COL_RND_W-1:0] rnd_col;
   logic [BANK_BITS-1:0] bank_q;
   logic [BANK_BITS-1:0] rot_bank;
   logic [RANK_BITS-1:0] rank_q;
   logic [RANK_BITS-1:0] rot_rank;
   logic [ROW_W-1:0]     row_q;
   logic [LFSR_W-1:0]    lfsr_q;
   logic                 dir_rd;

   // ---------------- configuration legality ----------------
   always_comb begin
      cfg_ok = pct_legal(cfg_rd_pct)
             && (cfg_banks_used != '0)
             && (cfg_banks_used <= (BANK_BITS+1)'(NUM_BANKS))
             && (cfg_ranks != '0)
             && (cfg_ranks <= (RANK_BITS+1)'(NUM_RANKS))
             && (cfg_series_len != '0)
             && (cfg_series_len <= (COL_BITS+1)'(COLS));
      mix_mode = (cfg_rd_pct == PCT_MIX);
      rd_all   = (cfg_rd_pct == PCT_READS);
      cfg_err  = !cfg_ok;
   end

   // ---------------- handshake and series start ----------------
   always_comb begin
      req_valid = (rem_q != '0) && cfg_ok;
      fire      = req_valid && req_ready;
      start     = cfg_ok && run_en &&
                  ((rem_q == '0) || ((rem_q == (COL_BITS+1)'(1)) && fire));
      req_write = !dir_rd;
   end

   // ---------------- page-safe start column ----------------
   always_comb begin
      col_span  = (COL_BITS+1)'(COLS) - cfg_series_len + (COL_BITS+1)'(1);
      span_safe = cfg_ok ? col_span : (COL_BITS+1)'(1);
      rnd_col   = lfsr_q[LFSR_W-1 -: COL_RND_W];
      start_col = COL_BITS'(rnd_col % COL_RND_W'(span_safe));
   end

   // ---------------- series state ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q  <= '0;
         col_q  <= '0;
         bank_q <= '0;
         rank_q <= '0;
         row_q  <= '0;
      end else if (!cfg_ok) begin
         rem_q <= '0;
      end else if (start) begin
         rem_q  <= cfg_series_len;
         col_q  <= start_col;
         bank_q <= rot_bank;
         rank_q <= rot_rank;
         row_q  <= lfsr_q[ROW_W-1:0];
      end else if (fire) begin
         rem_q <= rem_q - 1'b1;
         if (rem_q > (COL_BITS+1)'(1)) col_q <= col_q + 1'b1;
      end
   end

   rot_seq_lfsr #(
      .W    (LFSR_W)
   ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .step  (start),
      .state (lfsr_q)
   );

   rot_seq_rotation #(
      .BANK_BITS (BANK_BITS),
      .RANK_BITS (RANK_BITS)
   ) u_rot (
      .clk        (clk),
      .rst        (rst),
      .advance    (start),
      .banks_used (cfg_banks_used),
      .ranks      (cfg_ranks),
      .mix        (mix_mode),
      .rd_all     (rd_all),
      .bank_sel   (rot_bank),
      .rank_sel   (rot_rank),
      .dir_rd     (dir_rd)
   );

   rot_seq_addr_map #(
      .BLK_BITS  (BLK_BITS),
      .COL_BITS  (COL_BITS),
      .BANK_BITS (BANK_BITS),
      .RANK_BITS (RANK_BITS),
      .ROW_W     (ROW_W)
   ) u_map (
      .map_sel (addr_map_e'(cfg_map)),
      .row     (row_q),
      .rank    (rank_q),
      .bank    (bank_q),
      .col     (col_q),
      .addr    (req_addr)
   );

   // ---------------- assertions ----------------
   p_err_blocks_r1: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> !req_valid);

   p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_ready |=> cfg_err ||
         (req_valid && $stable(req_addr) && $stable(req_write)));

   p_page_fit_r7: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> ((COL_BITS+2)'(col_q) + (COL_BITS+2)'(rem_q)) <= (COL_BITS+2)'(COLS));

   p_no_bubble_r9: assert property (@(posedge clk) disable iff (rst)
      fire && (rem_q == (COL_BITS+1)'(1)) && run_en |=> req_valid || cfg_err);

   p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
      !req_valid && !run_en |=> !req_valid);

endmodule

// File: tb/rot_seq_gen_tb.sv
module rot_seq_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 32;
   localparam int BLK  = 6;
   localparam int COL  = 5;
   localparam int BANK = 3;
   localparam int RANK = 1;
   localparam int ROWW = AW - BLK - COL - BANK - RANK;
   localparam int COLS = 1 << COL;
   localparam int WATCHDOG = 100000;

   typedef struct packed {
      logic [6:0] pct;
      logic [3:0] banks;
      logic [1:0] ranks;
      logic [5:0] len;
      logic       map;
      logic [7:0] nser;
      logic       err;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{7'd100, 4'd8, 2'd2, 6'd4,  1'b1, 8'd20, 1'b0},
      '{7'd0,   4'd3, 2'd2, 6'd1,  1'b0, 8'd10, 1'b0},
      '{7'd50,  4'd4, 2'd2, 6'd2,  1'b1, 8'd20, 1'b0},
      '{7'd50,  4'd1, 2'd2, 6'd32, 1'b0, 8'd6,  1'b0},
      '{7'd100, 4'd5, 2'd1, 6'd3,  1'b0, 8'd7,  1'b0},
      '{7'd50,  4'd8, 2'd2, 6'd1,  1'b1, 8'd34, 1'b0},
      '{7'd30,  4'd4, 2'd1, 6'd2,  1'b1, 8'd0,  1'b1},
      '{7'd100, 4'd0, 2'd1, 6'd2,  1'b1, 8'd0,  1'b1},
      '{7'd100, 4'd4, 2'd3, 6'd2,  1'b1, 8'd0,  1'b1},
      '{7'd50,  4'd2, 2'd2, 6'd33, 1'b0, 8'd0,  1'b1}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          run_en = 1'b0;
   logic [6:0]    cfg_rd_pct = 7'd100;
   logic [BANK:0] cfg_banks_used = 4'd1;
   logic [RANK:0] cfg_ranks = 2'd1;
   logic [COL:0]  cfg_series_len = 6'd1;
   logic          cfg_map = 1'b1;
   logic          req_valid;
   logic          req_ready = 1'b1;
   logic [AW-1:0] req_addr;
   logic          req_write;
   logic          cfg_err;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   rot_seq_gen u_dut (
      .clk            (clk),
      .rst            (rst),
      .run_en         (run_en),
      .cfg_rd_pct     (cfg_rd_pct),
      .cfg_banks_used (cfg_banks_used),
      .cfg_ranks      (cfg_ranks),
      .cfg_series_len (cfg_series_len),
      .cfg_map        (cfg_map),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_addr       (req_addr),
      .req_write      (req_write),
      .cfg_err        (cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic decode(input logic [AW-1:0] a, input logic m,
                         output int bank, output int rank, output int col, output int row);
      if (m) begin
         col  = int'(a[BLK +: COL]);
         bank = int'(a[BLK+COL +: BANK]);
         rank = int'(a[BLK+COL+BANK +: RANK]);
      end else begin
         bank = int'(a[BLK +: BANK]);
         rank = int'(a[BLK+BANK +: RANK]);
         col  = int'(a[BLK+BANK+RANK +: COL]);
      end
      row = int'(a[AW-1 -: ROWW]);
   endtask

   function automatic int exp_write(input int pct, input int k, input int banks);
      if (pct == 100) return 0;
      if (pct == 0)   return 1;
      return (((k / banks) % 2) == 0) ? 0 : 1;
   endfunction

   task automatic wait_valid(input string tag);
      bit seen = 0;
      for (int i = 0; i < 20 && !seen; i++) begin
         @(negedge clk);
         if (req_valid) seen = 1;
      end
      chk(seen, tag, 0, 1);
   endtask

   task automatic apply_cfg(input vec_t t);
      @(negedge clk);
      rst = 1'b1; run_en = 1'b0; req_ready = 1'b1;
      cfg_rd_pct = t.pct; cfg_banks_used = t.banks; cfg_ranks = t.ranks;
      cfg_series_len = t.len; cfg_map = t.map;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      wait (cycles >= WATCHDOG);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int bank, rank, col, row, row0, col0, spr, wr;
      logic [AW-1:0] a0;

      // ---- table-driven runs ----
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         apply_cfg(t);
         chk(!req_valid, "R11 valid after reset", req_valid, 0);
         chk(cfg_err == t.err, "R1 error flag", cfg_err, t.err);
         run_en = 1'b1;
         if (t.err) begin
            for (int c = 0; c < 6; c++) begin
               @(negedge clk);
               chk(!req_valid && cfg_err, "R1 blocked", req_valid, 0);
            end
         end else begin
            wait_valid("R11 first series");
            spr = (t.pct == 50) ? 2 * int'(t.banks) : int'(t.banks);
            for (int k = 0; k < int'(t.nser); k++) begin
               for (int i = 0; i < int'(t.len); i++) begin
                  chk(req_valid, "R9 continuous stream", req_valid, 1);
                  decode(req_addr, t.map, bank, rank, col, row);
                  chk(bank == k % int'(t.banks), "R3 bank", bank, k % int'(t.banks));
                  chk(rank == (k / spr) % int'(t.ranks), "R4 rank", rank, (k / spr) % int'(t.ranks));
                  wr = exp_write(int'(t.pct), k, int'(t.banks));
                  chk(int'(req_write) == wr, (t.pct == 50) ? "R5 mix direction" : "R6 fixed direction",
                      req_write, wr);
                  chk(req_addr[BLK-1:0] == '0, "R8 low bits", req_addr[BLK-1:0], 0);
                  if (i == 0) begin
                     row0 = row; col0 = col;
                     chk(col0 + int'(t.len) <= COLS, "R7 start column", col0, COLS - int'(t.len));
                  end else begin
                     chk(row == row0 && col == col0 + i, "R2 column step", col, col0 + i);
                  end
                  @(negedge clk);
               end
            end
         end
      end

      // ---- stall holds the request (R2) ----
      apply_cfg('{7'd100, 4'd4, 2'd2, 6'd4, 1'b1, 8'd0, 1'b0});
      run_en = 1'b1;
      wait_valid("R2 stall setup");
      a0 = req_addr;
      decode(req_addr, 1'b1, bank, rank, col0, row0);
      req_ready = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(req_valid && req_addr == a0, "R2 stall hold", req_addr, a0);
      end
      req_ready = 1'b1;
      @(negedge clk);
      decode(req_addr, 1'b1, bank, rank, col, row);
      chk(col == col0 + 1 && row == row0, "R2 after stall", col, col0 + 1);

      // ---- run_en low lets the series finish, then pauses (R10) ----
      run_en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(req_valid, "R10 series completes", req_valid, 1);
         @(negedge clk);
      end
      for (int c = 0; c < 4; c++) begin
         chk(!req_valid, "R10 no new series", req_valid, 0);
         @(negedge clk);
      end
      run_en = 1'b1;
      wait_valid("R10 resume");
      decode(req_addr, 1'b1, bank, rank, col, row);
      chk(bank == 1, "R10 resume bank", bank, 1);
      chk(rank == 0, "R10 resume rank", rank, 0);

      // ---- reset mid-run restarts rotation (R11) ----
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!req_valid, "R11 valid cleared", req_valid, 0);
      wait_valid("R11 restart");
      decode(req_addr, 1'b1, bank, rank, col, row);
      chk(bank == 0 && rank == 0, "R11 rotation restarts", bank, 0);

      // ---- mix after reset starts with a read (R11, R5) ----
      apply_cfg('{7'd50, 4'd2, 2'd1, 6'd1, 1'b0, 8'd0, 1'b0});
      run_en = 1'b1;
      wait_valid("R11 mix start");
      chk(req_write == 1'b0, "R11 first mix series reads", req_write, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule